// File: doc/BRIEF.md
# Machine-Cycle Reset Qualifier

This block turns an active-high external reset pin into a clean internal reset for an 8051-style core whose machine cycle lasts 12 oscillator clocks. A free-running slot counter walks the six states of the cycle, two phases each. It raises a one-clock sample strobe in the fifth state, second phase. The pin first passes through a two-flop synchronizer and then a persistence filter, which rejects short pulses. A qualification state machine looks at the filtered level only on the sample strobe. It asserts the internal reset after two consecutive high samples and releases it at the first low sample.

While the internal reset is high, the block drives synchronous load strobes into a small special-function register bank. Each port latch is loaded with all ones and the stack pointer with 07h. The power-control register is cleared, except bit 4, which keeps its value. Every other register is cleared, except the serial data buffer, which keeps its contents. The bank also has a plain write port, so that a test can load values before a reset and see which ones survive it.

The qualification state machine has three states. In QS_IDLE the reset is low and no high sample is pending. In QS_ARMING at least one high sample has been seen and the reset is still low. In QS_ACTIVE the internal reset is asserted. Its transitions are T_ARM (QS_IDLE to QS_ARMING on a high sample), T_FIRE (QS_ARMING to QS_ACTIVE on the qualifying high sample), T_DISARM (QS_ARMING to QS_IDLE on a low sample) and T_RELEASE (QS_ACTIVE to QS_IDLE on a low sample). A high sample in QS_IDLE goes straight to QS_ACTIVE only if the qualification count is set to one.

Top module: `mc_reset_qualifier`

## Requirements
- R1: The slot counter counts 0 to 11 and wraps. The slot index is 2*(state-1)+(phase-1), so S5P2 is index 9. `mc_stb` is high for exactly one clock per machine cycle, while the index is 9, and the index is 0 after power-on reset.
- R2: `rst_int` rises one clock after the strobe at which the filtered pin level has been high at two consecutive strobes.
- R3: After the two-flop synchronizer, a change of the pin level is accepted only once it has persisted for 3 consecutive clocks. A pulse of 2 clocks or less never asserts `rst_int`.
- R4: A single low sample at a strobe clears the pending qualification. A pin that is high for only one strobe and then low does not assert `rst_int`.
- R5: Once `rst_int` is high, it falls one clock after the first strobe that samples the filtered level low.
- R6: On each clock with `rst_int` high, every port latch is loaded with FFh.
- R7: On each clock with `rst_int` high, the stack pointer is loaded with 07h.
- R8: On each clock with `rst_int` high, the power-control register is cleared in all bits except bit 4 (mask 10h), which keeps its value.
- R9: On each clock with `rst_int` high, the general special-function registers are loaded with 00h.
- R10: The serial buffer keeps its value while `rst_int` is high.
- R11: With `rst_int` low, a write with `wr_en` high updates the selected register on the next clock. The select codes are: 0 to 3 for ports 0 to 3, 4 for the stack pointer, 5 for the power-control register, 6 for the serial buffer, and 7 to 10 for general registers 0 to 3. Writes are ignored while `rst_int` is high.
- R12: While `por_n` is low, the bank holds its reset values (serial buffer and power-control register 00h), the state machine is in QS_IDLE and `rst_int` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| rst_pin | input | 1 | External active-high reset pin, asynchronous |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 4 | Register select code |
| wr_data | input | 8 | Write data |
| mc_stb | output | 1 | One-clock sample strobe at S5P2 |
| rst_int | output | 1 | Qualified internal reset |
| port_q | output | 32 | Port latches, port 0 in bits 7:0 |
| sp_q | output | 8 | Stack pointer |
| pcon_q | output | 8 | Power-control register |
| sfr_q | output | 32 | General registers, register 0 in bits 7:0 |
| sbuf_q | output | 8 | Serial data buffer |

## Verification
The hardest case to reach is a pin that is clean, passes the filter, and is high at exactly one strobe before it drops. Only this case drives the state machine through T_ARM and then T_DISARM without a reset following. The stimulus reaches it by holding the pin high for exactly 12 clocks, so that the filtered high window covers one sample slot and no more. Glitches of 2 clocks, and writes issued during an active reset, are placed so that a faulty filter or a faulty write gate would show up at the outputs. A behavioural model is compared with every output on every clock.

// File: rtl/rstq_pkg.sv
package rstq_pkg;
    typedef enum logic [1:0] {
        QS_IDLE   = 2'd0,
        QS_ARMING = 2'd1,
        QS_ACTIVE = 2'd2
    } qual_state_t;

    localparam logic [7:0] PORT_RST_VAL   = 8'hFF;
    localparam logic [7:0] SP_RST_VAL     = 8'h07;
    localparam logic [7:0] PCON_KEEP_MASK = 8'h10;
endpackage

// File: rtl/mc_slot_timer.sv
module mc_slot_timer #(
    parameter int CLKS_PER_MC = 12,
    parameter int SAMPLE_SLOT = 9
) (
    input  logic clk,
    input  logic por_n,
    output logic stb_o
);
    localparam int CW = $clog2(CLKS_PER_MC);
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_MC - 1);
    localparam logic [CW-1:0] SLOT = CW'(SAMPLE_SLOT);

    logic [CW-1:0] slot_cnt;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            slot_cnt <= '0;
        else if (slot_cnt == LAST)
            slot_cnt <= '0;
        else
            slot_cnt <= slot_cnt + 1'b1;
    end

    assign stb_o = (slot_cnt == SLOT);

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!por_n)
        stb_o |=> !stb_o); // R1
endmodule

// File: rtl/rst_glitch_filter.sv
module rst_glitch_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic por_n,
    input  logic pin_i,
    output logic lvl_o
);
    localparam int RW = $clog2(FILT_LEN + 1);
    localparam logic [RW-1:0] RUN_LAST = RW'(FILT_LEN - 1);

    logic          sync1, sync2;
    logic [RW-1:0] run_cnt;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
        end else begin
            sync1 <= pin_i;
            sync2 <= sync1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            lvl_o   <= 1'b0;
            run_cnt <= '0;
        end else if (sync2 == lvl_o) begin
            run_cnt <= '0;
        end else if (run_cnt == RUN_LAST) begin
            lvl_o   <= sync2;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    AST_FILT_FOLLOWS: assert property (@(posedge clk) disable iff (!por_n)
        !$stable(lvl_o) |-> (lvl_o == $past(sync2))); // R3
endmodule

// File: rtl/rst_qual_fsm.sv
module rst_qual_fsm
    import rstq_pkg::*;
#(
    parameter int QUAL_SAMPLES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic stb_i,
    input  logic lvl_i,
    output logic rst_o
);
    localparam int QW = $clog2(QUAL_SAMPLES + 1);
    localparam logic [QW-1:0] Q_LAST = QW'(QUAL_SAMPLES - 1);

    qual_state_t   state_q, state_d;
    logic [QW-1:0] hits_q, hits_d;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= QS_IDLE;
            hits_q  <= '0;
        end else begin
            state_q <= state_d;
            hits_q  <= hits_d;
        end
    end

    always_comb begin
        state_d = state_q;
        hits_d  = hits_q;
        unique case (state_q)
            QS_IDLE: begin
                if (stb_i && lvl_i) begin
                    if (QUAL_SAMPLES <= 1) begin
                        state_d = QS_ACTIVE;
                        hits_d  = '0;
                    end else begin
                        state_d = QS_ARMING;
                        hits_d  = QW'(1);
                    end
                end
            end
            QS_ARMING: begin
                if (stb_i) begin
                    if (!lvl_i) begin
                        state_d = QS_IDLE;
                        hits_d  = '0;
                    end else if (hits_q == Q_LAST) begin
                        state_d = QS_ACTIVE;
                        hits_d  = '0;
                    end else begin
                        hits_d  = hits_q + 1'b1;
                    end
                end
            end
            QS_ACTIVE: begin
                if (stb_i && !lvl_i) begin
                    state_d = QS_IDLE;
                    hits_d  = '0;
                end
            end
            default: begin
                state_d = QS_IDLE;
                hits_d  = '0;
            end
        endcase
    end

    always_comb begin
        rst_o = (state_q == QS_ACTIVE);
    end

    AST_RISE_ON_HIGH: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rst_o) |-> ($past(stb_i) && $past(lvl_i))); // R2
    AST_FALL_ON_LOW: assert property (@(posedge clk) disable iff (!por_n)
        $fell(rst_o) |-> ($past(stb_i) && !$past(lvl_i))); // R5
    AST_LOW_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
        (stb_i && !lvl_i) |=> (!rst_o && hits_q == '0)); // R4
endmodule

// File: rtl/sfr_bank.sv
module sfr_bank
    import rstq_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int NUM_SFR   = 4,
    parameter int DW        = 8,
    parameter int SEL_W     = 4
) (
    input  logic                    clk,
    input  logic                    por_n,
    input  logic                    load_i,
    input  logic                    wr_en,
    input  logic [SEL_W-1:0]        wr_sel,
    input  logic [DW-1:0]           wr_data,
    output logic [NUM_PORTS*DW-1:0] port_o,
    output logic [DW-1:0]           sp_o,
    output logic [DW-1:0]           pcon_o,
    output logic [NUM_SFR*DW-1:0]   sfr_o,
    output logic [DW-1:0]           sbuf_o
);
    localparam int SEL_SP   = NUM_PORTS;
    localparam int SEL_PCON = NUM_PORTS + 1;
    localparam int SEL_SBUF = NUM_PORTS + 2;
    localparam int SEL_GEN  = NUM_PORTS + 3;
    localparam logic [DW-1:0] KEEP = DW'(PCON_KEEP_MASK);

    logic wr_ok;
    assign wr_ok = wr_en && !load_i;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)
                port_o[p*DW +: DW] <= DW'(PORT_RST_VAL);
            else if (load_i)
                port_o[p*DW +: DW] <= DW'(PORT_RST_VAL);
            else if (wr_ok && wr_sel == SEL_W'(p))
                port_o[p*DW +: DW] <= wr_data;
        end
    end

    for (genvar g = 0; g < NUM_SFR; g++) begin : g_gen
        always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)
                sfr_o[g*DW +: DW] <= '0;
            else if (load_i)
                sfr_o[g*DW +: DW] <= '0;
            else if (wr_ok && wr_sel == SEL_W'(SEL_GEN + g))
                sfr_o[g*DW +: DW] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            sp_o   <= DW'(SP_RST_VAL);
            pcon_o <= '0;
            sbuf_o <= '0;
        end else if (load_i) begin
            sp_o   <= DW'(SP_RST_VAL);
            pcon_o <= pcon_o & KEEP;
        end else if (wr_ok) begin
            if (wr_sel == SEL_W'(SEL_SP))   sp_o   <= wr_data;
            if (wr_sel == SEL_W'(SEL_PCON)) pcon_o <= wr_data;
            if (wr_sel == SEL_W'(SEL_SBUF)) sbuf_o <= wr_data;
        end
    end

    AST_PORTS_ONES: assert property (@(posedge clk) disable iff (!por_n)
        load_i |=> (port_o == '1)); // R6
    AST_SP_SEVEN: assert property (@(posedge clk) disable iff (!por_n)
        load_i |=> (sp_o == DW'(SP_RST_VAL))); // R7
    AST_PCON_KEEP: assert property (@(posedge clk) disable iff (!por_n)
        load_i |=> (pcon_o == ($past(pcon_o) & KEEP))); // R8
    AST_GEN_ZERO: assert property (@(posedge clk) disable iff (!por_n)
        load_i |=> (sfr_o == '0)); // R9
    AST_SBUF_HELD: assert property (@(posedge clk) disable iff (!por_n)
        load_i |=> $stable(sbuf_o)); // R10
endmodule

// File: rtl/mc_reset_qualifier.sv
module mc_reset_qualifier #(
    parameter int CLKS_PER_MC  = 12,
    parameter int SAMPLE_SLOT  = 9,
    parameter int QUAL_SAMPLES = 2,
    parameter int FILT_LEN     = 3,
    parameter int NUM_PORTS    = 4,
    parameter int NUM_SFR      = 4,
    parameter int DW           = 8,
    parameter int SEL_W        = $clog2(NUM_PORTS + NUM_SFR + 3)
) (
    input  logic                    clk,
    input  logic                    por_n,
    input  logic                    rst_pin,
    input  logic                    wr_en,
    input  logic [SEL_W-1:0]        wr_sel,
    input  logic [DW-1:0]           wr_data,
    output logic                    mc_stb,
    output logic                    rst_int,
    output logic [NUM_PORTS*DW-1:0] port_q,
    output logic [DW-1:0]           sp_q,
    output logic [DW-1:0]           pcon_q,
    output logic [NUM_SFR*DW-1:0]   sfr_q,
    output logic [DW-1:0]           sbuf_q
);
    logic filt_lvl;

    mc_slot_timer #(.CLKS_PER_MC(CLKS_PER_MC), .SAMPLE_SLOT(SAMPLE_SLOT)) u_timer (
        .clk(clk), .por_n(por_n), .stb_o(mc_stb));

    rst_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filter (
        .clk(clk), .por_n(por_n), .pin_i(rst_pin), .lvl_o(filt_lvl));

    rst_qual_fsm #(.QUAL_SAMPLES(QUAL_SAMPLES)) u_fsm (
        .clk(clk), .por_n(por_n), .stb_i(mc_stb), .lvl_i(filt_lvl), .rst_o(rst_int));

    sfr_bank #(.NUM_PORTS(NUM_PORTS), .NUM_SFR(NUM_SFR), .DW(DW), .SEL_W(SEL_W)) u_bank (
        .clk(clk), .por_n(por_n), .load_i(rst_int),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .port_o(port_q), .sp_o(sp_q), .pcon_o(pcon_q), .sfr_o(sfr_q), .sbuf_o(sbuf_q));

    AST_NO_RESET_IN_POR: assert property (@(posedge clk) disable iff (!por_n)
        $rose(por_n) |-> !rst_int); // R12
endmodule

// File: tb/tb_mc_reset_qualifier.sv
module tb_mc_reset_qualifier;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        rst_pin = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_sel = '0;
    logic [7:0]  wr_data = '0;
    logic        mc_stb, rst_int;
    logic [31:0] port_q, sfr_q;
    logic [7:0]  sp_q, pcon_q, sbuf_q;

    int checks = 0;
    int errors = 0;
    bit saw_rst = 0;
    bit done = 0;

    mc_reset_qualifier dut (
        .clk(clk), .por_n(por_n), .rst_pin(rst_pin), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .mc_stb(mc_stb), .rst_int(rst_int),
        .port_q(port_q), .sp_q(sp_q), .pcon_q(pcon_q), .sfr_q(sfr_q), .sbuf_q(sbuf_q));

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference
    int   m_slot, m_run, m_hits, m_phase;   // m_phase: 0 idle, 1 arming, 2 active
    bit   m_p1, m_p2, m_lvl;
    logic [7:0] m_reg[11];                  // index = select code

    function automatic logic [31:0] pack4(int base);
        logic [31:0] v;
        for (int i = 0; i < 4; i++) v[i*8 +: 8] = m_reg[base + i];
        return v;
    endfunction

    always @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            m_slot = 0; m_run = 0; m_hits = 0; m_phase = 0;
            m_p1 = 0; m_p2 = 0; m_lvl = 0;
            for (int i = 0; i < 11; i++) m_reg[i] = (i < 4) ? 8'hFF : (i == 4 ? 8'h07 : 8'h00);
        end else begin
            bit strobe, active, lvl_old;
            strobe  = (m_slot == 9);
            active  = (m_phase == 2);
            lvl_old = m_lvl;
            m_slot  = (m_slot + 1) % 12;
            if (m_p2 == m_lvl) m_run = 0;
            else if (m_run == 2) begin m_lvl = m_p2; m_run = 0; end
            else m_run++;
            m_p2 = m_p1;
            m_p1 = rst_pin;
            if (strobe) begin
                if (!lvl_old) begin m_phase = 0; m_hits = 0; end
                else if (m_phase == 0) begin m_phase = 1; m_hits = 1; end
                else if (m_phase == 1) begin m_phase = 2; m_hits = 0; end
            end
            if (active) begin
                for (int i = 0; i < 4; i++) m_reg[i] = 8'hFF;
                m_reg[4] = 8'h07;
                m_reg[5] = m_reg[5] & 8'h10;
                for (int i = 7; i < 11; i++) m_reg[i] = 8'h00;
            end else if (wr_en && wr_sel < 11) begin
                m_reg[wr_sel] = wr_data;
            end
        end
    end

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_int) saw_rst = 1;
        if (por_n && !done) begin
            check(mc_stb == (m_slot == 9), "R1 strobe", 32'(mc_stb), 32'(m_slot == 9));
            check(rst_int == (m_phase == 2), "R2/R3/R4/R5 rst_int", 32'(rst_int), 32'(m_phase == 2));
            check(port_q == pack4(0), "R6 ports", port_q, pack4(0));
            check(sp_q == m_reg[4], "R7 sp", 32'(sp_q), 32'(m_reg[4]));
            check(pcon_q == m_reg[5], "R8 pcon", 32'(pcon_q), 32'(m_reg[5]));
            check(sfr_q == pack4(7), "R9 sfr", sfr_q, pack4(7));
            check(sbuf_q == m_reg[6], "R10 sbuf", 32'(sbuf_q), 32'(m_reg[6]));
        end
    end

    task automatic write_reg(int sel, logic [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_sel = 4'(sel); wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        idle(3);
        // R12: power-on values
        check(rst_int == 0 && port_q == '1 && sp_q == 8'h07 && pcon_q == 0 && sbuf_q == 0 && sfr_q == 0,
              "R12 por values", {port_q[7:0], sp_q, pcon_q, 7'b0, rst_int}, {8'hFF, 8'h07, 8'h00, 8'h00});
        por_n = 1;
        idle(2);
        // R11: load every register
        for (int s = 0; s < 11; s++) write_reg(s, 8'(8'h30 + s * 7));
        write_reg(5, 8'hFF);
        check(pcon_q == 8'hFF && sbuf_q == 8'(8'h30 + 42), "R11 writes land",
              {pcon_q, sbuf_q}, {8'hFF, 8'(8'h30 + 42)});
        // R3: two-clock glitches at several offsets
        saw_rst = 0;
        for (int k = 0; k < 12; k++) begin
            rst_pin = 1; idle(2); rst_pin = 0; idle(5);
        end
        idle(30);
        check(!saw_rst, "R3 glitch rejected", 32'(saw_rst), 0);
        // R4: high for exactly one strobe, then low
        while (!mc_stb) @(negedge clk);
        idle(6);
        rst_pin = 1; idle(12); rst_pin = 0;
        idle(40);
        check(!saw_rst, "R4 single sample clears", 32'(saw_rst), 0);
        // R2: long high
        rst_pin = 1; idle(40);
        check(rst_int == 1, "R2 reset asserted", 32'(rst_int), 1);
        check(port_q == '1 && sp_q == 8'h07, "R6 R7 reset values", {port_q[15:0], sp_q}, {16'hFFFF, 8'h07});
        check(pcon_q == 8'h10 && sfr_q == 0, "R8 R9 reset values", {pcon_q, sfr_q[7:0]}, {8'h10, 8'h00});
        check(sbuf_q == 8'(8'h30 + 42), "R10 sbuf kept", 32'(sbuf_q), 32'(8'h30 + 42));
        // R11: writes while reset is active are ignored
        write_reg(4, 8'hAA); write_reg(7, 8'h55); write_reg(6, 8'h99);
        check(sp_q == 8'h07 && sfr_q[7:0] == 0 && sbuf_q == 8'(8'h30 + 42), "R11 ignored in reset",
              {sp_q, sfr_q[7:0], sbuf_q}, {8'h07, 8'h00, 8'(8'h30 + 42)});
        // R5: release
        rst_pin = 0; idle(30);
        check(rst_int == 0, "R5 released", 32'(rst_int), 0);
        // R8: second reset with bit 4 clear
        write_reg(5, 8'hEF);
        write_reg(6, 8'h3C);
        rst_pin = 1; idle(40); rst_pin = 0; idle(30);
        check(pcon_q == 8'h00 && sbuf_q == 8'h3C, "R8 R10 second reset", {pcon_q, sbuf_q}, {8'h00, 8'h3C});
        // R12: power-on reset mid-run
        rst_pin = 1; idle(30);
        por_n = 0; idle(2);
        check(rst_int == 0 && sbuf_q == 0 && pcon_q == 0, "R12 por clears", {rst_int, pcon_q, sbuf_q}, 0);
        por_n = 1; rst_pin = 0; idle(30);
        finish_run();
    end
endmodule